// File: doc/BRIEF.md
# Call/Return Stack Controller

This block keeps a hardware stack of return points and sequences subroutine calls and returns for a small processor core. Each stack entry is 16 bits wide and pairs an 8-bit program counter (low byte) with an 8-bit program page (high byte). When the core issues a call, the block saves the address of the instruction after the call, together with the current page. It then asks the program counter to load the target address. When the core issues a return, the block takes the newest entry off the stack and asks the program counter to resume there. A return also raises a separate return-skip flag next to the normal skip.

Plain push and pop strobes give the core direct access to the same stack. A push stores the current PC and page unchanged. A pop shows the removed entry on the data output. Pushing onto a full stack or popping from an empty one leaves the stack as it was and sets a sticky error flag.

The sequencer has three named states. `ST_IDLE` accepts strobes. `ST_CALL` drives a one-cycle redirect to the call target. `ST_RET` drives a one-cycle redirect to the restored point. The transitions are:

- IDLE→CALL: a lone call strobe is accepted while the stack is not full.
- IDLE→RET: a lone return strobe is accepted while the stack is not empty.
- CALL→IDLE and RET→IDLE: always, after one cycle.
- IDLE→IDLE: every other case, which covers push, pop, no strobe, several strobes at once, and errors.

Top module: `cstk_ctrl`

## Requirements
- R1: After reset the stack is empty, `skip_o`, `func_skip_o` and `err_o` are 0, and `new_pc_o`, `new_page_o` and `stk_data_o` are 0.
- R2: A call accepted in idle stores the entry {page_i, pc_i+1}, with the PC in bits 7:0 and the page in bits 15:8 and the increment wrapping from 255 to 0. In the next cycle `skip_o`=1, `func_skip_o`=0, `new_pc_o`=target_i and `new_page_o`=page_i.
- R3: A return accepted in idle removes the newest entry. In the next cycle `skip_o`=1 and `func_skip_o`=1, `new_pc_o` and `new_page_o` show bits 7:0 and 15:8 of that entry, and `stk_data_o` holds the whole entry.
- R4: A push stores {page_i, pc_i}. A pop removes the newest entry and presents it on `stk_data_o` from the next cycle until the next pop or return. Neither one raises skip. Entries come back in last-in first-out order.
- R5: The stack holds DEPTH=256 entries. A push or call while full stores nothing, leaves the stack unchanged, raises no skip and sets `err_o`.
- R6: A pop or return while empty leaves the stack and `stk_data_o` unchanged, raises no skip and sets `err_o`.
- R7: Once `err_o` is set it stays 1 until reset.
- R8: When two or more of the four strobes are high in the same cycle, the block does nothing: no store, no removal, no skip, no error.
- R9: Strobes that arrive in a cycle where `skip_o` is 1 are ignored.
- R10: `skip_o` is high for exactly one cycle per accepted call or return, and `func_skip_o` is never high without `skip_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push {page_i, pc_i} |
| pop_i | input | 1 | Pop the newest entry to stk_data_o |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| pc_i | input | 8 | Current program counter |
| page_i | input | 8 | Current program page |
| target_i | input | 8 | Call target address |
| stk_data_o | output | 16 | Last entry removed by a pop or return |
| skip_o | output | 1 | Redirect request to the program counter |
| func_skip_o | output | 1 | Redirect is a return |
| new_pc_o | output | 8 | Redirect PC |
| new_page_o | output | 8 | Redirect page |
| err_o | output | 1 | Sticky overflow/underflow error |

## Verification
The assertions take for granted that strobes change only between clock edges and are valid in every cycle after reset. They do not assume the core leaves gaps between strobes, avoids full or empty operations, or never raises several strobes at once. The stimulus therefore drives each strobe across one whole clock period, starting just after a falling edge. It deliberately includes back-to-back strobes during the redirect cycle, simultaneous strobes, overflow and underflow.

// File: rtl/cstk_pkg.sv
package cstk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALL = 2'd1,
        ST_RET  = 2'd2
    } cstk_state_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } cstk_op_e;

endpackage

// File: rtl/cstk_decode.sv
module cstk_decode
    import cstk_pkg::*;
(
    input  logic     push_i,
    input  logic     pop_i,
    input  logic     call_i,
    input  logic     ret_i,
    output cstk_op_e op_o
);
    logic [2:0] n_active;

    always_comb begin
        n_active = 3'(push_i) + 3'(pop_i) + 3'(call_i) + 3'(ret_i);
        op_o     = OP_NONE;
        if (n_active == 3'd1) begin
            if (call_i)      op_o = OP_CALL;
            else if (ret_i)  op_o = OP_RET;
            else if (push_i) op_o = OP_PUSH;
            else             op_o = OP_POP;
        end
    end
endmodule

// File: rtl/cstk_mem.sv
module cstk_mem #(
    parameter int DEPTH = 256,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/cstk_ptr.sv
module cstk_ptr #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [PW-1:0] sp,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] top_idx
);
    localparam logic [PW-1:0] LIMIT = PW'(DEPTH);

    logic [PW-1:0] sp_m1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sp <= '0;
        else if (inc && !dec) sp <= sp + PW'(1);
        else if (dec && !inc) sp <= sp_m1;
    end

    assign sp_m1   = sp - PW'(1);
    assign full    = (sp == LIMIT);
    assign empty   = (sp == '0);
    assign wr_idx  = sp[AW-1:0];
    assign top_idx = sp_m1[AW-1:0];
endmodule

// File: rtl/cstk_seq.sv
module cstk_seq
    import cstk_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int PAGE_W = 8,
    localparam int DW    = PC_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cstk_op_e          op,
    input  logic              full,
    input  logic              empty,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [DW-1:0]     top_entry,
    output logic              we,
    output logic [DW-1:0]     wdata,
    output logic              inc,
    output logic              dec,
    output logic [DW-1:0]     stk_data_o,
    output logic              skip_o,
    output logic              func_skip_o,
    output logic [PC_W-1:0]   new_pc_o,
    output logic [PAGE_W-1:0] new_page_o,
    output logic              err_o
);
    cstk_state_e state, nxt;

    logic              cap_rd;
    logic              cap_tgt;
    logic              err_set;
    logic [DW-1:0]     rd_q;
    logic [PC_W-1:0]   tgt_pc_q;
    logic [PAGE_W-1:0] tgt_pg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions and stack actions
    always_comb begin
        nxt     = state;
        we      = 1'b0;
        inc     = 1'b0;
        dec     = 1'b0;
        cap_rd  = 1'b0;
        cap_tgt = 1'b0;
        err_set = 1'b0;
        wdata   = {page_i, pc_i};
        unique case (state)
            ST_IDLE: begin
                case (op)
                    OP_CALL: begin
                        if (full) begin
                            err_set = 1'b1;
                        end else begin
                            wdata   = {page_i, pc_i + PC_W'(1)};
                            we      = 1'b1;
                            inc     = 1'b1;
                            cap_tgt = 1'b1;
                            nxt     = ST_CALL;
                        end
                    end
                    OP_RET: begin
                        if (empty) begin
                            err_set = 1'b1;
                        end else begin
                            dec    = 1'b1;
                            cap_rd = 1'b1;
                            nxt    = ST_RET;
                        end
                    end
                    OP_PUSH: begin
                        if (full) begin
                            err_set = 1'b1;
                        end else begin
                            we  = 1'b1;
                            inc = 1'b1;
                        end
                    end
                    OP_POP: begin
                        if (empty) begin
                            err_set = 1'b1;
                        end else begin
                            dec    = 1'b1;
                            cap_rd = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            ST_CALL: nxt = ST_IDLE;
            ST_RET:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q     <= '0;
            tgt_pc_q <= '0;
            tgt_pg_q <= '0;
            err_o    <= 1'b0;
        end else begin
            if (cap_rd)  rd_q <= top_entry;
            if (cap_tgt) begin
                tgt_pc_q <= target_i;
                tgt_pg_q <= page_i;
            end
            if (err_set) err_o <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        skip_o      = 1'b0;
        func_skip_o = 1'b0;
        new_pc_o    = '0;
        new_page_o  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_CALL: begin
                skip_o     = 1'b1;
                new_pc_o   = tgt_pc_q;
                new_page_o = tgt_pg_q;
            end
            ST_RET: begin
                skip_o      = 1'b1;
                func_skip_o = 1'b1;
                new_pc_o    = rd_q[PC_W-1:0];
                new_page_o  = rd_q[DW-1:PC_W];
            end
            default: ;
        endcase
    end

    assign stk_data_o = rd_q;
endmodule

// File: rtl/cstk_ctrl.sv
module cstk_ctrl
    import cstk_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int PC_W   = 8,
    parameter int PAGE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic                     call_i,
    input  logic                     ret_i,
    input  logic [PC_W-1:0]          pc_i,
    input  logic [PAGE_W-1:0]        page_i,
    input  logic [PC_W-1:0]          target_i,
    output logic [PC_W+PAGE_W-1:0]   stk_data_o,
    output logic                     skip_o,
    output logic                     func_skip_o,
    output logic [PC_W-1:0]          new_pc_o,
    output logic [PAGE_W-1:0]        new_page_o,
    output logic                     err_o
);
    localparam int DW = PC_W + PAGE_W;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    cstk_op_e      op_w;
    logic          we_w, inc_w, dec_w, full_w, empty_w;
    logic [PW-1:0] sp_w;
    logic [AW-1:0] wr_idx_w, top_idx_w;
    logic [DW-1:0] wdata_w, top_entry_w;

    cstk_decode u_dec (
        .push_i (push_i),
        .pop_i  (pop_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .op_o   (op_w)
    );

    cstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc_w),
        .dec     (dec_w),
        .sp      (sp_w),
        .full    (full_w),
        .empty   (empty_w),
        .wr_idx  (wr_idx_w),
        .top_idx (top_idx_w)
    );

    cstk_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (we_w),
        .waddr (wr_idx_w),
        .wdata (wdata_w),
        .raddr (top_idx_w),
        .rdata (top_entry_w)
    );

    cstk_seq #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op_w),
        .full        (full_w),
        .empty       (empty_w),
        .pc_i        (pc_i),
        .page_i      (page_i),
        .target_i    (target_i),
        .top_entry   (top_entry_w),
        .we          (we_w),
        .wdata       (wdata_w),
        .inc         (inc_w),
        .dec         (dec_w),
        .stk_data_o  (stk_data_o),
        .skip_o      (skip_o),
        .func_skip_o (func_skip_o),
        .new_pc_o    (new_pc_o),
        .new_page_o  (new_page_o),
        .err_o       (err_o)
    );
endmodule

// File: rtl/cstk_ctrl_chk.sv
module cstk_ctrl_chk #(
    parameter int DEPTH = 256,
    parameter int PW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic          call_i,
    input logic          ret_i,
    input logic          skip_o,
    input logic          func_skip_o,
    input logic          err_o,
    input logic [PW-1:0] sp,
    input logic          full,
    input logic          empty
);
    logic [3:0] strobes;
    assign strobes = {push_i, pop_i, call_i, ret_i};

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sp) <= DEPTH);

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_o && full && (push_i || call_i) && $countones(strobes) == 1)
        |=> ($stable(sp) && !skip_o && err_o));

    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_o && empty && (pop_i || ret_i) && $countones(strobes) == 1)
        |=> ($stable(sp) && !skip_o && err_o));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_multi_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_o && $countones(strobes) > 1) |=> ($stable(sp) && !skip_o));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> $stable(sp));

    p_call_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_o && call_i && !full && $countones(strobes) == 1)
        |=> (skip_o && !func_skip_o));

    p_ret_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_o && ret_i && !empty && $countones(strobes) == 1)
        |=> (skip_o && func_skip_o));

    p_skip_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> !skip_o);

    p_func_needs_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        func_skip_o |-> skip_o);
endmodule

bind cstk_ctrl cstk_ctrl_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .skip_o      (skip_o),
    .func_skip_o (func_skip_o),
    .err_o       (err_o),
    .sp          (sp_w),
    .full        (full_w),
    .empty       (empty_w)
);

// File: tb/sim_cstk_ctrl.sv
`timescale 1ns/1ps
module sim_cstk_ctrl;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0;
    logic [7:0]  pc_i = 0, page_i = 0, target_i = 0;
    logic [15:0] stk_data_o;
    logic        skip_o, func_skip_o, err_o;
    logic [7:0]  new_pc_o, new_page_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cstk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .call_i(call_i), .ret_i(ret_i), .pc_i(pc_i), .page_i(page_i),
        .target_i(target_i), .stk_data_o(stk_data_o), .skip_o(skip_o),
        .func_skip_o(func_skip_o), .new_pc_o(new_pc_o),
        .new_page_o(new_page_o), .err_o(err_o)
    );

    // behavioural reference model
    logic [15:0] mq[$];
    int          m_st = 0;        // 0 idle, 1 after call, 2 after return
    logic [7:0]  m_tpc = 0, m_tpg = 0;
    logic [15:0] m_rd = 0;
    bit          m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            m_st = 0; m_tpc = 0; m_tpg = 0; m_rd = 0; m_err = 0;
        end else if (m_st != 0) begin
            m_st = 0;
        end else if (int'(push_i) + int'(pop_i) + int'(call_i) + int'(ret_i) == 1) begin
            if (call_i) begin
                if (mq.size() == DEPTH) m_err = 1;
                else begin
                    mq.push_back({page_i, 8'(pc_i + 8'd1)});
                    m_tpc = target_i; m_tpg = page_i; m_st = 1;
                end
            end else if (ret_i) begin
                if (mq.size() == 0) m_err = 1;
                else begin m_rd = mq.pop_back(); m_st = 2; end
            end else if (push_i) begin
                if (mq.size() == DEPTH) m_err = 1;
                else mq.push_back({page_i, pc_i});
            end else begin
                if (mq.size() == 0) m_err = 1;
                else m_rd = mq.pop_back();
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 skip", 32'(skip_o), 32'(m_st != 0));
            chk("R3 func_skip", 32'(func_skip_o), 32'(m_st == 2));
            chk("R2 new_pc", 32'(new_pc_o),
                32'(m_st == 1 ? m_tpc : (m_st == 2 ? m_rd[7:0] : 8'd0)));
            chk("R3 new_page", 32'(new_page_o),
                32'(m_st == 1 ? m_tpg : (m_st == 2 ? m_rd[15:8] : 8'd0)));
            chk("R4 stk_data", 32'(stk_data_o), 32'(m_rd));
            chk("R7 err", 32'(err_o), 32'(m_err));
        end
    end

    task automatic drive(input logic c, input logic r, input logic pu, input logic po,
                         input logic [7:0] pc, input logic [7:0] pg, input logic [7:0] tg);
        @(negedge clk);
        call_i = c; ret_i = r; push_i = pu; pop_i = po;
        pc_i = pc; page_i = pg; target_i = tg;
        @(negedge clk);
        call_i = 0; ret_i = 0; push_i = 0; pop_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 skip after reset", 32'(skip_o), 0);
        chk("R1 err after reset", 32'(err_o), 0);
        chk("R1 data after reset", 32'(stk_data_o), 0);

        // R4 push/pop LIFO
        drive(0, 0, 1, 0, 8'h11, 8'h22, 8'h00);
        drive(0, 0, 1, 0, 8'h33, 8'h44, 8'h00);
        drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        chk("R4 pop newest", 32'(stk_data_o), 32'h4433);
        chk("R4 pop no skip", 32'(skip_o), 0);

        // R2 call, nested call with PC wrap, R3 returns
        drive(1, 0, 0, 0, 8'h10, 8'h05, 8'h80);
        chk("R2 skip", 32'(skip_o), 1);
        chk("R2 target", 32'(new_pc_o), 32'h80);
        chk("R2 page", 32'(new_page_o), 32'h05);
        chk("R2 no func_skip", 32'(func_skip_o), 0);
        @(negedge clk);
        chk("R10 skip one cycle", 32'(skip_o), 0);
        drive(1, 0, 0, 0, 8'hFF, 8'h06, 8'h90);
        drive(0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 wrap pc", 32'(new_pc_o), 32'h00);
        chk("R3 page", 32'(new_page_o), 32'h06);
        chk("R3 func_skip", 32'(func_skip_o), 1);
        drive(0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 second return", 32'({new_page_o, new_pc_o}), 32'h0511);
        drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        chk("R4 bottom entry", 32'(stk_data_o), 32'h2211);

        // R8 simultaneous strobes
        drive(0, 0, 1, 0, 8'hA1, 8'hB2, 8'h00);
        drive(0, 0, 1, 1, 8'h55, 8'h66, 8'h00);
        chk("R8 push+pop no data change", 32'(stk_data_o), 32'h2211);
        drive(1, 1, 0, 0, 8'h55, 8'h66, 8'h77);
        chk("R8 call+ret no skip", 32'(skip_o), 0);
        drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        chk("R8 stack intact", 32'(stk_data_o), 32'hB2A1);

        // R9 strobe during redirect cycle ignored
        drive(1, 0, 0, 0, 8'h40, 8'h03, 8'hC0);
        call_i = 0; push_i = 1; pc_i = 8'hEE; page_i = 8'hEE;
        @(negedge clk);
        push_i = 0;
        drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        chk("R9 busy push ignored", 32'(stk_data_o), 32'h0341);

        // R6 underflow, R7 sticky
        drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        chk("R6 pop empty err", 32'(err_o), 1);
        chk("R6 data unchanged", 32'(stk_data_o), 32'h0341);
        drive(0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R6 ret empty no skip", 32'(skip_o), 0);
        drive(0, 0, 1, 0, 8'h01, 8'h02, 8'h00);
        chk("R7 err stays", 32'(err_o), 1);

        // R5 overflow
        do_reset();
        @(negedge clk);
        chk("R1 err cleared", 32'(err_o), 0);
        for (int i = 0; i < DEPTH; i++) drive(0, 0, 1, 0, 8'(i), 8'(i ^ 8'h5A), 8'h00);
        chk("R5 full no err yet", 32'(err_o), 0);
        drive(0, 0, 1, 0, 8'h99, 8'h99, 8'h00);
        chk("R5 push full err", 32'(err_o), 1);
        drive(1, 0, 0, 0, 8'h12, 8'h34, 8'h56);
        chk("R5 call full no skip", 32'(skip_o), 0);
        drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        chk("R5 top unchanged", 32'(stk_data_o), 32'({8'hFF ^ 8'h5A, 8'hFF}));
        drive(0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 return after full", 32'({new_page_o, new_pc_o}), 32'({8'hFE ^ 8'h5A, 8'hFE}));

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule